// File: doc/BRIEF.md
# Machine Double-Trap Guard

This block watches each machine-mode trap request on its way into a processor core and decides what happens to it. It keeps a one-bit guard flag, the machine double-trap flag (MDT). The flag is raised whenever a trap is accepted. It is lowered by the return instructions, or it is written directly by software. If a trap arrives while the flag is still raised and the guard feature is enabled, the trap is not handed to the normal trap path. It is escalated instead.

The escalation target depends on a configuration input. When the core has a resumable non-maskable interrupt facility, the escalated trap becomes an NMI request. When it has none, the block raises an abort that halts the core. The abort holds until the next reset. The flag value is exported so that the status register can show it.

Top module: `mdt_trap_guard`

## Requirements
- R1: After reset, MDT reads 1, the abort output is 0, and with no trap request both trap_take and nmi_req are 0.
- R2: When no abort is latched and MDT is 0, a trap request asserts trap_take in the same cycle, with nmi_req 0. Every accepted trap request sets MDT to 1 from the next cycle.
- R3: When the guard is enabled (guard_en=1), MDT is 1, no abort is latched and rnmi_present=1, a trap request asserts nmi_req in the same cycle and keeps trap_take at 0.
- R4: When the guard is enabled, MDT is 1, no abort is latched and rnmi_present=0, a trap request keeps trap_take and nmi_req at 0 and raises abort_hold from the next cycle.
- R5: Once abort_hold is 1, it stays 1 until reset. While it is 1, trap_take and nmi_req stay 0 and MDT holds its value whatever the inputs do.
- R6: With no trap request and no software write, a ret_mret or ret_mnret pulse clears MDT to 0 from the next cycle.
- R7: A ret_sret pulse clears MDT only when cur_priv equals the machine encoding 2'b11. At any other privilege value it leaves MDT unchanged.
- R8: With guard_en=0 and no abort latched, every trap request asserts trap_take, whatever the MDT value, and never produces nmi_req or an abort.
- R9: A software write (mdt_we=1) loads mdt_wdata into MDT from the next cycle.
- R10: The update priority is fixed. A trap request outranks a software write, and a software write outranks any return pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| guard_en | input | 1 | Enables double-trap escalation |
| rnmi_present | input | 1 | Core has a resumable NMI facility |
| trap_req | input | 1 | Machine-mode trap request this cycle |
| cur_priv | input | 2 | Current privilege level (2'b11 = machine) |
| ret_mret | input | 1 | Machine return executed |
| ret_mnret | input | 1 | NMI return executed |
| ret_sret | input | 1 | Supervisor return executed |
| mdt_we | input | 1 | Software write strobe for MDT |
| mdt_wdata | input | 1 | Software write value for MDT |
| trap_take | output | 1 | Trap is taken through the normal path |
| nmi_req | output | 1 | Trap escalated to an NMI request |
| abort_hold | output | 1 | Latched abort/halt |
| mdt | output | 1 | Current MDT value |

## Verification
The bench targets the cycle in which a trap request collides with a return pulse or a software write. A design with the wrong priority would leave MDT at 0 after the trap, and the next trap would slip through unescalated. It applies ret_sret at each non-machine privilege. A design that decoded privilege loosely would clear the flag and lose double-trap protection. It also repeats traps after an abort, to catch a latch that releases or a halted core that still takes traps. Disabled-guard cycles with MDT held at 1 catch a design that escalates when the feature is off.

// File: rtl/mdt_pkg.sv
// Package: shared types for the double-trap guard.
// Assumes a two-bit privilege field in which all ones means machine mode.
package mdt_pkg;
    localparam int PRIV_W = 2;
    localparam logic [PRIV_W-1:0] PRIV_MACHINE = 2'b11;

    // Outcome of one trap request.
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_TAKE  = 2'd1,
        ACT_NMI   = 2'd2,
        ACT_ABORT = 2'd3
    } trap_act_e;
endpackage

// File: rtl/mdt_escalate.sv
// Module: mdt_escalate
// Purely combinational classifier. It decides whether a trap request goes
// through the normal path, becomes an NMI, or becomes an abort.
// Assumes halted is the latched abort state; a halted core accepts nothing.
module mdt_escalate
    import mdt_pkg::*;
(
    input  logic      guard_en,
    input  logic      rnmi_present,
    input  logic      trap_req,
    input  logic      mdt_q,
    input  logic      halted,
    output trap_act_e act
);
    logic nested;

    // A nested trap exists only while the guard is enabled and MDT is set.
    assign nested = guard_en & mdt_q;

    // Classify the request.
    always_comb begin
        act = ACT_NONE;
        if (trap_req && !halted) begin
            if (!nested)           act = ACT_TAKE;
            else if (rnmi_present) act = ACT_NMI;
            else                   act = ACT_ABORT;
        end
    end
endmodule

// File: rtl/mdt_flag_reg.sv
// Module: mdt_flag_reg
// Holds the MDT bit. The update priority is: an accepted trap request sets it,
// then a software write loads it, then a return pulse clears it.
// Assumes the caller has already qualified ret_clr with privilege.
module mdt_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic halted,
    input  logic trap_seen,
    input  logic wr_en,
    input  logic wr_val,
    input  logic ret_clr,
    output logic mdt_q
);
    // MDT state update; it resets to 1 and is frozen while halted.
    always_ff @(posedge clk) begin
        if (!rst_n)         mdt_q <= 1'b1;
        else if (halted)    mdt_q <= mdt_q;
        else if (trap_seen) mdt_q <= 1'b1;
        else if (wr_en)     mdt_q <= wr_val;
        else if (ret_clr)   mdt_q <= 1'b0;
    end
endmodule

// File: rtl/mdt_abort_latch.sv
// Module: mdt_abort_latch
// Sticky abort flag. It is set by one fire pulse and released only by reset.
module mdt_abort_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic halted
);
    // Latch the abort until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) halted <= 1'b0;
        else        halted <= halted | fire;
    end
endmodule

// File: rtl/mdt_trap_guard.sv
// Module: mdt_trap_guard (top)
// Double-trap supervision for machine-mode trap entry. It ties together the
// classifier, the MDT register and the abort latch.
// Assumes trap_req marks only traps that target machine mode.
module mdt_trap_guard
    import mdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              guard_en,
    input  logic              rnmi_present,
    input  logic              trap_req,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic              ret_mret,
    input  logic              ret_mnret,
    input  logic              ret_sret,
    input  logic              mdt_we,
    input  logic              mdt_wdata,
    output logic              trap_take,
    output logic              nmi_req,
    output logic              abort_hold,
    output logic              mdt
);
    trap_act_e act;
    logic      mdt_q;
    logic      halted;
    logic      ret_clr;
    logic      sret_ok;

    // sret clears MDT only when it executes in machine mode.
    assign sret_ok = ret_sret & (cur_priv == PRIV_MACHINE);
    assign ret_clr = ret_mret | ret_mnret | sret_ok;

    mdt_escalate u_esc (
        .guard_en     (guard_en),
        .rnmi_present (rnmi_present),
        .trap_req     (trap_req),
        .mdt_q        (mdt_q),
        .halted       (halted),
        .act          (act)
    );

    mdt_flag_reg u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .halted    (halted),
        .trap_seen (act != ACT_NONE),
        .wr_en     (mdt_we),
        .wr_val    (mdt_wdata),
        .ret_clr   (ret_clr),
        .mdt_q     (mdt_q)
    );

    mdt_abort_latch u_abort (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (act == ACT_ABORT),
        .halted (halted)
    );

    // Drive the outputs from the classification and the stored state.
    assign trap_take  = (act == ACT_TAKE);
    assign nmi_req    = (act == ACT_NMI);
    assign abort_hold = halted;
    assign mdt        = mdt_q;
endmodule

// File: rtl/mdt_trap_guard_chk.sv
// Module: mdt_trap_guard_chk
// Port-level property checker for mdt_trap_guard, attached by bind.
module mdt_trap_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       guard_en,
    input logic       rnmi_present,
    input logic       trap_req,
    input logic [1:0] cur_priv,
    input logic       ret_mret,
    input logic       ret_mnret,
    input logic       ret_sret,
    input logic       mdt_we,
    input logic       trap_take,
    input logic       nmi_req,
    input logic       abort_hold,
    input logic       mdt
);
    // R2: an accepted trap leaves MDT set.
    a_r2_take_sets_mdt: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> mdt);

    // R3: a nested trap with a resumable NMI present becomes an NMI.
    a_r3_nested_to_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_en && trap_req && mdt && rnmi_present && !abort_hold)
        |-> (nmi_req && !trap_take));

    // R4: a nested trap without an NMI facility aborts.
    a_r4_nested_to_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_en && trap_req && mdt && !rnmi_present && !abort_hold)
        |=> abort_hold);

    // R5: the abort is sticky, and nothing is taken while halted.
    a_r5_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        abort_hold |=> abort_hold);
    a_r5_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        abort_hold |-> (!trap_take && !nmi_req));

    // R6: a machine or NMI return clears MDT.
    a_r6_ret_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort_hold && !trap_req && !mdt_we && (ret_mret || ret_mnret))
        |=> !mdt);

    // R7: sret outside machine mode leaves MDT unchanged.
    a_r7_sret_non_m: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && !mdt_we && !ret_mret && !ret_mnret && ret_sret
         && cur_priv != 2'b11)
        |=> $stable(mdt));

    // R8: with the guard off, every trap is taken normally.
    a_r8_disabled_take: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard_en && trap_req && !abort_hold) |-> (trap_take && !nmi_req));

    // The two trap outcomes never occur together.
    a_r3_outcome_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_take && nmi_req));
endmodule

bind mdt_trap_guard mdt_trap_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .guard_en     (guard_en),
    .rnmi_present (rnmi_present),
    .trap_req     (trap_req),
    .cur_priv     (cur_priv),
    .ret_mret     (ret_mret),
    .ret_mnret    (ret_mnret),
    .ret_sret     (ret_sret),
    .mdt_we       (mdt_we),
    .trap_take    (trap_take),
    .nmi_req      (nmi_req),
    .abort_hold   (abort_hold),
    .mdt          (mdt)
);

// File: tb/sim_mdt_trap_guard.sv
// Bench: seeded random traffic plus directed corner cases, checked against
// a reference model built from the requirements.
module sim_mdt_trap_guard;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic guard_en = 1'b0, rnmi_present = 1'b0, trap_req = 1'b0;
    logic [1:0] cur_priv = 2'b00;
    logic ret_mret = 1'b0, ret_mnret = 1'b0, ret_sret = 1'b0;
    logic mdt_we = 1'b0, mdt_wdata = 1'b0;
    logic trap_take, nmi_req, abort_hold, mdt;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit m_mdt, m_abort;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdt_trap_guard u0 (
        .clk(clk), .rst_n(rst_n), .guard_en(guard_en),
        .rnmi_present(rnmi_present), .trap_req(trap_req),
        .cur_priv(cur_priv), .ret_mret(ret_mret), .ret_mnret(ret_mnret),
        .ret_sret(ret_sret), .mdt_we(mdt_we), .mdt_wdata(mdt_wdata),
        .trap_take(trap_take), .nmi_req(nmi_req),
        .abort_hold(abort_hold), .mdt(mdt)
    );

    // Reference: expected normal take.
    function automatic bit exp_take();
        return trap_req && !m_abort && !(guard_en && m_mdt);
    endfunction

    // Reference: expected NMI escalation.
    function automatic bit exp_nmi();
        return trap_req && !m_abort && guard_en && m_mdt && rnmi_present;
    endfunction

    // Reference: state advance at a clock edge.
    task automatic model_step();
        if (!m_abort) begin
            if (trap_req && guard_en && m_mdt && !rnmi_present) m_abort = 1'b1;
            if (trap_req) m_mdt = 1'b1;
            else if (mdt_we) m_mdt = mdt_wdata;
            else if (ret_mret || ret_mnret || (ret_sret && cur_priv == 2'b11))
                m_mdt = 1'b0;
        end
    endtask

    task automatic chk(input string tag, input bit act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Check all outputs mid-cycle, then advance the model at the edge.
    task automatic cyc(input string tag);
        #1;
        chk(tag, trap_take,  exp_take(), "trap_take");
        chk(tag, nmi_req,    exp_nmi(),  "nmi_req");
        chk(tag, abort_hold, m_abort,    "abort_hold");
        chk(tag, mdt,        m_mdt,      "mdt");
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        trap_req = 0; ret_mret = 0; ret_mnret = 0; ret_sret = 0;
        mdt_we = 0; mdt_wdata = 0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_mdt = 1'b1;
        m_abort = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_2025));
        @(negedge clk);
        do_reset();
        guard_en = 1; rnmi_present = 1; cur_priv = 2'b11;
        cyc("R1");
        // R6: mret clears, then R2: a trap with MDT=0 is taken.
        ret_mret = 1; cyc("R6"); idle();
        trap_req = 1; cyc("R2"); idle();
        cyc("R2");
        // R3: nested trap escalates to an NMI.
        trap_req = 1; cyc("R3"); idle();
        // R6: mnret clears.
        ret_mnret = 1; cyc("R6"); idle(); cyc("R6");
        // R9: software write sets, then clears.
        mdt_we = 1; mdt_wdata = 1; cyc("R9"); idle(); cyc("R9");
        mdt_we = 1; mdt_wdata = 0; cyc("R9"); idle(); cyc("R9");
        // R7: sret at each non-machine privilege leaves MDT set.
        mdt_we = 1; mdt_wdata = 1; cyc("R9"); idle();
        for (int p = 0; p < 3; p++) begin
            cur_priv = p[1:0]; ret_sret = 1; cyc("R7"); idle(); cyc("R7");
        end
        cur_priv = 2'b11; ret_sret = 1; cyc("R7"); idle(); cyc("R7");
        // R10: a trap with mret and a clearing write in the same cycle.
        trap_req = 1; ret_mret = 1; mdt_we = 1; mdt_wdata = 0; cyc("R10"); idle(); cyc("R10");
        // R10: a write of 1 together with mret.
        ret_mret = 1; cyc("R10"); idle();
        mdt_we = 1; mdt_wdata = 1; ret_mret = 1; cyc("R10"); idle(); cyc("R10");
        // R8: guard off, so a trap with MDT=1 is taken.
        guard_en = 0; rnmi_present = 0; trap_req = 1; cyc("R8"); cyc("R8"); idle(); cyc("R8");
        // R4: guard on, no NMI facility, nested trap aborts.
        guard_en = 1; trap_req = 1; cyc("R4"); idle(); cyc("R4");
        // R5: the abort holds and nothing is accepted or changed.
        trap_req = 1; rnmi_present = 1; cyc("R5"); idle();
        ret_mret = 1; cyc("R5"); idle();
        mdt_we = 1; mdt_wdata = 0; cyc("R5"); idle(); cyc("R5");
        guard_en = 0; trap_req = 1; cyc("R5"); idle();
        do_reset(); cyc("R1");

        // Random phases, each starting from reset.
        for (int ph = 0; ph < 12; ph++) begin
            do_reset();
            for (int i = 0; i < 300; i++) begin
                guard_en     = ($urandom % 8) != 0;
                rnmi_present = ($urandom % 16) != 0;
                trap_req     = ($urandom % 3) == 0;
                cur_priv     = 2'($urandom % 4);
                ret_mret     = ($urandom % 6) == 0;
                ret_mnret    = ($urandom % 8) == 0;
                ret_sret     = ($urandom % 4) == 0;
                mdt_we       = ($urandom % 8) == 0;
                mdt_wdata    = 1'($urandom % 2);
                cyc("R2/R3/R4/R5/R6/R7/R8/R9/R10");
            end
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule